// File: doc/BRIEF.md
# Buffered Synchronous Serial Transfer Engine

This block moves a run of bytes between a 32-entry on-chip byte buffer and a four-wire synchronous serial link. Software loads the buffer, programs a first and a last buffer index, and writes the start bit. The engine then sends each byte, most significant bit first, and stores the byte received during that byte time at the same index. The index steps upward from the first index and wraps from 31 to 0. When the last index has been exchanged, the engine drops its busy bit and raises an interrupt request.

The serial clock is either generated inside the block or taken from the link. The internal clock is a fixed divide of the system clock, with an optional idle gap between bytes. A low-active chip-select input can be used to hold off the start of a transfer. When that option is enabled, the same input aborts a running transfer if it goes high. While a transfer is running or pending, the CPU has no access to the buffer. When the engine is stopped, the data output holds its last level, and software can set that level directly.

Register map (CPU address bit AW set): index 0 is control, index 1 is first index, index 2 is last index, index 3 is status. Control bits are: bit 0 selects the external clock, bit 1 enables chip-select gating, bit 2 enables the byte strobe, and bits 3 and up hold the gap count. Status bits are: bit 0 busy/start, bit 1 interrupt request, bit 2 wait, bit 3 abort, bit 4 overrun, bit 7 data-output level.

Top module: `bufser_engine`

## Requirements
- R1: After reset: status reads 0x80 (idle, all flags clear, output level 1); the serial clock output is high; both output enables are high; the interrupt output is low.
- R2: A transfer exchanges every index from first to last inclusive, stepping up and wrapping from 31 to 0, and no other index. Each byte goes out most significant bit first, changing on the falling serial clock edge. Each received byte, sampled on rising edges, replaces the sent byte at the same index.
- R3: When the last index completes, status bit 0 clears and status bit 1 and the interrupt output are set.
- R4: While status bit 0 is set, a buffer read returns 0xFF and a buffer write leaves the buffer unchanged. Either access sets status bit 2.
- R5: With control bit 1 set, a started transfer makes no serial clock edge until chip select is low.
- R6: With control bit 1 set, chip select going high during a transfer ends it. Bit 0 clears, bits 3 and 1 set, and both output enables stay low until bit 3 is cleared.
- R7: Writing 1 to status bit 0 while status bit 3 is set starts nothing.
- R8: With the internal clock, the serial clock is high outside transfers. Its high time between bytes is HALF_DIV plus gap times 2*HALF_DIV system clocks, and HALF_DIV within a byte.
- R9: With control bit 0 set, the transfer is clocked by the serial clock input and the clock output enable is low.
- R10: In external clock mode, a falling edge on the serial clock input after a completed transfer sets status bit 4 and moves no data. This does not happen when control bit 1 is set and chip select is high.
- R11: While stopped, the data output holds the last bit sent. A status write while idle sets the data output to the written bit 7.
- R12: Status bits 1 to 4 are sticky. Writing 0 clears a bit; writing 1 leaves it unchanged; a new event in the same cycle as a clearing write wins.
- R13: With control bit 2 set, the strobe output pulses for one cycle per exchanged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | AW+1 | Buffer index, or register index when bit AW is set |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data (combinational) |
| sck_i | input | 1 | Serial clock input (external mode) |
| sck_o | output | 1 | Serial clock output (idles high) |
| sck_oe | output | 1 | Serial clock output enable |
| so_o | output | 1 | Serial data output |
| so_oe | output | 1 | Serial data output enable |
| si_i | input | 1 | Serial data input |
| cs_n_i | input | 1 | Active-low chip select |
| strb_o | output | 1 | One-cycle byte strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH 32, DW 8, GAPW 3 and HALF_DIV 2. A byte then takes 32 system clocks, so wrapped runs, multi-byte gaps, mid-byte aborts and slow external clocks all fit in short directed tests. A full-depth buffer lets the wrap from index 31 to 0 be checked against untouched neighbouring indices. A gap count of 2 gives a measured inter-byte high time of 10 clocks, against 2 clocks within a byte.

// File: rtl/bufser_pkg.sv
package bufser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAITCS = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_GAP    = 2'd3
  } bs_state_e;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_FIRST = 2'd1;
  localparam logic [1:0] REG_LAST  = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  localparam int C_EXT  = 0;
  localparam int C_GATE = 1;
  localparam int C_STRB = 2;
  localparam int C_GAP  = 3;

  localparam int S_BUSY  = 0;
  localparam int S_IRQ   = 1;
  localparam int S_WAIT  = 2;
  localparam int S_ABORT = 3;
  localparam int S_OVR   = 4;
  localparam int S_LVL   = 7;

  function automatic int next_index(input int idx, input int depth);
    return (idx + 1) % depth;
  endfunction

  function automatic int gap_cycles(input int gap, input int half);
    return gap * 2 * half;
  endfunction

endpackage

// File: rtl/bufser_mem.sv
module bufser_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/bufser_clkgen.sv
module bufser_clkgen #(
  parameter int HALF_DIV = 4,
  localparam int CW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic run,
  input  logic sck_i,
  output logic sck_o,
  output logic fall_tick,
  output logic rise_tick,
  output logic ext_fall
);

  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic [2:0]    sync_q;
  logic          ext_rise;
  logic          int_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sck_i};
  end

  assign ext_fall = sync_q[2] & ~sync_q[1];
  assign ext_rise = ~sync_q[2] & sync_q[1];
  assign int_edge = run && !ext_mode && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run || ext_mode) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (int_edge) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fall_tick = ext_mode ? (run & ext_fall) : (int_edge & sck_q);
  assign rise_tick = ext_mode ? (run & ext_rise) : (int_edge & ~sck_q);
  assign sck_o     = sck_q;

endmodule

// File: rtl/bufser_shift.sv
module bufser_shift #(
  parameter int DW   = 8,
  localparam int BW  = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rise_tick,
  input  logic [DW-1:0] tx_byte,
  input  logic          si,
  output logic          bit_out,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);

  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic [BW-1:0] bitcnt_q;
  logic [DW-2:0] rx_q;

  assign bit_out   = tx_byte[BIT_LAST - bitcnt_q];
  assign byte_done = rise_tick && (bitcnt_q == BIT_LAST);
  assign rx_byte   = {rx_q, si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q <= '0;
      rx_q     <= '0;
    end else if (clear) begin
      bitcnt_q <= '0;
    end else if (rise_tick) begin
      rx_q     <= rx_byte[DW-2:0];
      bitcnt_q <= byte_done ? '0 : bitcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bufser_engine.sv
module bufser_engine
  import bufser_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int DW       = 8,
  parameter int HALF_DIV = 4,
  parameter int GAPW     = 3,
  localparam int AW      = $clog2(DEPTH),
  localparam int GCW     = $clog2(((1 << GAPW) - 1) * 2 * HALF_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   cpu_addr,
  input  logic          cpu_we,
  input  logic          cpu_re,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          so_o,
  output logic          so_oe,
  input  logic          si_i,
  input  logic          cs_n_i,
  output logic          strb_o,
  output logic          irq_o
);

  bs_state_e      state_q;
  logic           ext_mode_q, gate_q, strb_en_q;
  logic [GAPW-1:0] gap_q;
  logic [AW-1:0]  first_q, last_q, cur_q;
  logic [GCW-1:0] gap_cnt_q;
  logic           irq_q, wait_q, abort_q, ovr_q, so_q, done_seen_q, strb_q;
  logic [1:0]     cs_sync_q;
  logic           cs_hi;

  logic           is_reg, stat_wr, busy, active, run;
  logic [1:0]     reg_idx;
  logic           evt_start, evt_abort, evt_byte, evt_done, evt_blocked, evt_overrun;
  logic           fall_tick, rise_tick, ext_fall, bit_out;
  logic [DW-1:0]  tx_byte, rx_byte, cpu_buf_rd;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr;
  logic [DW-1:0]  mem_wdata;

  // ---------------- decode and events ----------------
  assign is_reg  = cpu_addr[AW];
  assign reg_idx = cpu_addr[1:0];
  assign stat_wr = cpu_we && is_reg && (reg_idx == REG_STAT);
  assign busy    = (state_q != ST_IDLE);
  assign active  = (state_q == ST_SHIFT) || (state_q == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_sync_q <= 2'b11;
    else        cs_sync_q <= {cs_sync_q[0], cs_n_i};
  end
  assign cs_hi = cs_sync_q[1];

  assign evt_blocked = !is_reg && (cpu_we || cpu_re) && busy;
  assign evt_start   = stat_wr && cpu_wdata[S_BUSY] && !busy && !abort_q;
  assign evt_abort   = active && gate_q && cs_hi;
  assign run         = (state_q == ST_SHIFT) && !evt_abort;
  assign evt_byte    = rise_tick && byte_done_w;
  assign evt_done    = evt_byte && (cur_q == last_q);
  assign evt_overrun = ext_mode_q && !busy && done_seen_q && ext_fall
                       && !(gate_q && cs_hi);

  // ---------------- datapath blocks ----------------
  logic byte_done_w;

  bufser_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_mode  (ext_mode_q),
    .run       (run),
    .sck_i     (sck_i),
    .sck_o     (sck_o),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .ext_fall  (ext_fall)
  );

  bufser_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (evt_start || evt_abort),
    .rise_tick (rise_tick),
    .tx_byte   (tx_byte),
    .si        (si_i),
    .bit_out   (bit_out),
    .byte_done (byte_done_w),
    .rx_byte   (rx_byte)
  );

  assign mem_we    = evt_byte || (cpu_we && !is_reg && !busy);
  assign mem_waddr = evt_byte ? cur_q : cpu_addr[AW-1:0];
  assign mem_wdata = evt_byte ? rx_byte : cpu_wdata;

  bufser_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (cur_q),
    .rdata_a (tx_byte),
    .raddr_b (cpu_addr[AW-1:0]),
    .rdata_b (cpu_buf_rd)
  );

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode_q <= 1'b0;
      gate_q     <= 1'b0;
      strb_en_q  <= 1'b0;
      gap_q      <= '0;
      first_q    <= '0;
      last_q     <= '0;
    end else if (cpu_we && is_reg) begin
      case (reg_idx)
        REG_CTRL: begin
          ext_mode_q <= cpu_wdata[C_EXT];
          gate_q     <= cpu_wdata[C_GATE];
          strb_en_q  <= cpu_wdata[C_STRB];
          gap_q      <= cpu_wdata[C_GAP +: GAPW];
        end
        REG_FIRST: first_q <= cpu_wdata[AW-1:0];
        REG_LAST:  last_q  <= cpu_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      gap_cnt_q   <= '0;
      done_seen_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (evt_start) begin
          state_q     <= ST_WAITCS;
          cur_q       <= first_q;
          done_seen_q <= 1'b0;
        end
        ST_WAITCS: if (!gate_q || !cs_hi) state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (evt_abort) begin
            state_q <= ST_IDLE;
          end else if (evt_done) begin
            state_q     <= ST_IDLE;
            done_seen_q <= 1'b1;
          end else if (evt_byte) begin
            cur_q <= AW'(next_index(int'(cur_q), DEPTH));
            if (!ext_mode_q && (gap_q != '0)) begin
              state_q   <= ST_GAP;
              gap_cnt_q <= GCW'(gap_cycles(int'(gap_q), HALF_DIV) - 1);
            end
          end
        end
        ST_GAP: begin
          if (evt_abort)              state_q <= ST_IDLE;
          else if (gap_cnt_q == '0)   state_q <= ST_SHIFT;
          else                        gap_cnt_q <= gap_cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- sticky flags, output level, strobe ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      wait_q  <= 1'b0;
      abort_q <= 1'b0;
      ovr_q   <= 1'b0;
      so_q    <= 1'b1;
      strb_q  <= 1'b0;
    end else begin
      if (evt_done || evt_abort) irq_q <= 1'b1;
      else if (stat_wr)          irq_q <= irq_q & cpu_wdata[S_IRQ];
      if (evt_blocked)           wait_q <= 1'b1;
      else if (stat_wr)          wait_q <= wait_q & cpu_wdata[S_WAIT];
      if (evt_abort)             abort_q <= 1'b1;
      else if (stat_wr)          abort_q <= abort_q & cpu_wdata[S_ABORT];
      if (evt_overrun)           ovr_q <= 1'b1;
      else if (stat_wr)          ovr_q <= ovr_q & cpu_wdata[S_OVR];
      if (fall_tick)             so_q <= bit_out;
      else if (stat_wr && !busy) so_q <= cpu_wdata[S_LVL];
      strb_q <= evt_byte && strb_en_q;
    end
  end

  // ---------------- CPU read mux ----------------
  always_comb begin
    cpu_rdata = '0;
    if (!is_reg) begin
      cpu_rdata = busy ? '1 : cpu_buf_rd;
    end else begin
      case (reg_idx)
        REG_CTRL: begin
          cpu_rdata[C_EXT]         = ext_mode_q;
          cpu_rdata[C_GATE]        = gate_q;
          cpu_rdata[C_STRB]        = strb_en_q;
          cpu_rdata[C_GAP +: GAPW] = gap_q;
        end
        REG_FIRST: cpu_rdata = DW'(first_q);
        REG_LAST:  cpu_rdata = DW'(last_q);
        default: begin
          cpu_rdata[S_BUSY]  = busy;
          cpu_rdata[S_IRQ]   = irq_q;
          cpu_rdata[S_WAIT]  = wait_q;
          cpu_rdata[S_ABORT] = abort_q;
          cpu_rdata[S_OVR]   = ovr_q;
          cpu_rdata[S_LVL]   = so_q;
        end
      endcase
    end
  end

  assign so_o   = so_q;
  assign so_oe  = !abort_q;
  assign sck_oe = !ext_mode_q && !abort_q;
  assign strb_o = strb_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/bufser_engine_chk.sv
module bufser_engine_chk #(
  parameter int AW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        evt_abort,
  input logic        evt_done,
  input logic        evt_blocked,
  input logic        evt_overrun,
  input logic        abort_q,
  input logic        wait_q,
  input logic        ovr_q,
  input logic        ext_mode_q,
  input logic        irq_o,
  input logic        so_oe,
  input logic        sck_oe,
  input logic        sck_o,
  input logic        so_o,
  input logic        cpu_we
);

  a_r6_abort_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> (abort_q && irq_o && !busy && !so_oe && !sck_oe));

  a_r3_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> (irq_o && !busy));

  a_r7_abort_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !busy) |=> !busy);

  a_r4_wait_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_blocked |=> wait_q);

  a_r8_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sck_o);

  a_r10_overrun_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> (!busy && ext_mode_q) ##1 ovr_q);

  a_r11_so_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(cpu_we)) |-> $stable(so_o));

endmodule

bind bufser_engine bufser_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/bufser_engine_bench.sv
module bufser_engine_bench;

  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam int HALF  = 2;
  localparam int GAPW  = 3;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW:0] A_CTRL  = 6'h20;
  localparam logic [AW:0] A_FIRST = 6'h21;
  localparam logic [AW:0] A_LAST  = 6'h22;
  localparam logic [AW:0] A_STAT  = 6'h23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW:0] cpu_addr = '0;
  logic cpu_we = 1'b0, cpu_re = 1'b0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic sck_i = 1'b1, sck_o, sck_oe, so_o, so_oe, si_i, strb_o, irq_o;
  logic cs_n_i = 1'b1;
  logic use_ext = 1'b0, ext_si = 1'b0, slv_si = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign si_i = use_ext ? ext_si : slv_si;

  bufser_engine #(.DEPTH(DEPTH), .DW(DW), .HALF_DIV(HALF), .GAPW(GAPW)) u_bufser_engine (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe), .si_i(si_i), .cs_n_i(cs_n_i),
    .strb_o(strb_o), .irq_o(irq_o)
  );

  // ---------------- slave model on the internal clock ----------------
  logic [7:0] slv_tx [8];
  logic [7:0] mst_cap [8];
  int fcnt = 0, rcnt = 0, strb_cnt = 0;
  realtime t_fall [64];
  realtime t_rise [64];

  always @(negedge sck_o) begin
    if (fcnt < 64) begin
      t_fall[fcnt] = $realtime;
      slv_si = slv_tx[(fcnt / 8) % 8][7 - (fcnt % 8)];
    end
    fcnt++;
  end

  always @(posedge sck_o) begin
    if (rcnt < 64) begin
      t_rise[rcnt] = $realtime;
      mst_cap[(rcnt / 8) % 8][7 - (rcnt % 8)] = so_o;
    end
    rcnt++;
  end

  always @(posedge clk) if (strb_o) strb_cnt++;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [AW:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int guard;
    guard = 0;
    do begin
      rd(A_STAT, s);
      guard++;
    end while (s[0] && guard < 3000);
    chk({req, " transfer finishes"}, int'(s[0]), 0);
  endtask

  task automatic clear_counts();
    fcnt = 0; rcnt = 0; strb_cnt = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] s;
    rd(A_STAT, s);
    chk("R1 status after reset", s, 8'h80);
    chk("R1 sck_o idle", sck_o, 1);
    chk("R1 sck_oe", sck_oe, 1);
    chk("R1 so_oe", so_oe, 1);
    chk("R1 irq_o", irq_o, 0);
  endtask

  task automatic t_basic();
    logic [7:0] m [4];
    logic [7:0] d;
    m = '{8'hA5, 8'h3C, 8'h0F, 8'h81};
    slv_tx[0] = 8'h5A; slv_tx[1] = 8'hC3; slv_tx[2] = 8'hF0; slv_tx[3] = 8'h7E;
    for (int i = 0; i < 4; i++) wr(6'(4 + i), m[i]);
    wr(6'd3, 8'h11); wr(6'd8, 8'h22);
    wr(A_CTRL, 8'h04); wr(A_FIRST, 8'd4); wr(A_LAST, 8'd7);
    clear_counts();
    wr(A_STAT, 8'h81);
    wait_idle("R3");
    chk("R3 irq_o after completion", irq_o, 1);
    for (int i = 0; i < 4; i++) begin
      rd(6'(4 + i), d);
      chk("R2 received byte stored in place", d, slv_tx[i]);
      chk("R2 sent byte MSB first", mst_cap[i], m[i]);
    end
    rd(6'd3, d); chk("R2 index below range untouched", d, 8'h11);
    rd(6'd8, d); chk("R2 index above range untouched", d, 8'h22);
    chk("R13 strobe count", strb_cnt, 4);
    chk("R11 so_o holds last bit", so_o, 1);
    wr(A_STAT, 8'h82);
    chk("R12 writing 1 keeps irq", irq_o, 1);
    wr(A_STAT, 8'h00);
    chk("R12 writing 0 clears irq", irq_o, 0);
    chk("R11 level write drives so_o", so_o, 0);
    wr(A_STAT, 8'h80);
    chk("R11 level write drives so_o high", so_o, 1);
  endtask

  task automatic t_wrap();
    logic [7:0] m [4];
    logic [7:0] d;
    int idx [4];
    m = '{8'h12, 8'hE7, 8'h6D, 8'hB0};
    idx = '{30, 31, 0, 1};
    slv_tx[0] = 8'h01; slv_tx[1] = 8'h80; slv_tx[2] = 8'hAA; slv_tx[3] = 8'h55;
    for (int i = 0; i < 4; i++) wr(6'(idx[i]), m[i]);
    wr(6'd2, 8'h99); wr(6'd29, 8'h98);
    wr(A_CTRL, 8'h00); wr(A_FIRST, 8'd30); wr(A_LAST, 8'd1);
    clear_counts();
    wr(A_STAT, 8'h81);
    wait_idle("R2 wrap");
    for (int i = 0; i < 4; i++) begin
      rd(6'(idx[i]), d);
      chk("R2 wrapped index receives", d, slv_tx[i]);
      chk("R2 wrapped index sends", mst_cap[i], m[i]);
    end
    rd(6'd2, d);  chk("R2 wrap stops at last", d, 8'h99);
    rd(6'd29, d); chk("R2 wrap starts at first", d, 8'h98);
    chk("R13 no strobe when disabled", strb_cnt, 0);
    wr(A_STAT, 8'h80);
  endtask

  task automatic t_gap();
    slv_tx[0] = 8'h00; slv_tx[1] = 8'hFF;
    wr(6'd10, 8'h5F); wr(6'd11, 8'hF5);
    wr(A_CTRL, 8'h10); wr(A_FIRST, 8'd10); wr(A_LAST, 8'd11);
    clear_counts();
    wr(A_STAT, 8'h81);
    wait_idle("R8 gap");
    chk("R8 high time within byte (ns)", int'(t_fall[1] - t_rise[0]), HALF * 8);
    chk("R8 high time between bytes (ns)", int'(t_fall[8] - t_rise[7]), (HALF + 2 * 2 * HALF) * 8);
    chk("R8 clock edges per run", fcnt, 16);
    chk("R8 sck_o idle high after run", sck_o, 1);
    wr(A_STAT, 8'h80);
  endtask

  task automatic t_blocked();
    logic [7:0] d;
    slv_tx[0] = 8'hC9;
    wr(6'd0, 8'h44);
    wr(A_CTRL, 8'h02); wr(A_FIRST, 8'd0); wr(A_LAST, 8'd0);
    cs_n_i = 1'b1;
    clear_counts();
    wr(A_STAT, 8'h81);
    repeat (40) @(negedge clk);
    chk("R5 no clock edge while chip select high", fcnt, 0);
    rd(6'd0, d);
    chk("R4 blocked read returns 0xFF", d, 8'hFF);
    wr(6'd0, 8'h77);
    rd(A_STAT, d);
    chk("R4 wait flag and busy", d, 8'h85);
    cs_n_i = 1'b0;
    wait_idle("R5");
    chk("R4 blocked write left buffer unchanged", mst_cap[0], 8'h44);
    rd(6'd0, d);
    chk("R2 received byte after gated start", d, 8'hC9);
    rd(A_STAT, d);
    chk("R12 wait flag sticky after completion", d & 8'h1F, 8'h06);
    wr(A_STAT, 8'h80);
    rd(A_STAT, d);
    chk("R12 flags cleared by writing 0", d & 8'h1F, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    int guard, fsave;
    wr(A_CTRL, 8'h02); wr(A_FIRST, 8'd0); wr(A_LAST, 8'd3);
    cs_n_i = 1'b0;
    clear_counts();
    wr(A_STAT, 8'h81);
    guard = 0;
    while (rcnt < 5 && guard < 500) begin @(negedge clk); guard++; end
    cs_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 so_oe low after abort", so_oe, 0);
    chk("R6 sck_oe low after abort", sck_oe, 0);
    chk("R6 irq_o after abort", irq_o, 1);
    rd(A_STAT, d);
    chk("R6 status after abort", d & 8'h1F, 8'h0A);
    cs_n_i = 1'b0;
    fsave = fcnt;
    wr(A_STAT, 8'h8B);
    repeat (20) @(negedge clk);
    rd(A_STAT, d);
    chk("R7 start refused while abort set", d & 8'h1F, 8'h0A);
    chk("R7 no clock edge after refused start", fcnt, fsave);
    wr(A_STAT, 8'h80);
    chk("R6 so_oe back after abort cleared", so_oe, 1);
    chk("R6 sck_oe back after abort cleared", sck_oe, 1);
  endtask

  task automatic ext_bit(input logic b, output logic sent);
    sck_i = 1'b0; ext_si = b;
    repeat (8) @(negedge clk);
    sent = so_o;
    sck_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_ext();
    logic [7:0] d, cap;
    logic [7:0] in_b;
    in_b = 8'h3B;
    use_ext = 1'b1;
    cs_n_i = 1'b0;
    wr(6'd5, 8'hC6);
    wr(A_CTRL, 8'h01); wr(A_FIRST, 8'd5); wr(A_LAST, 8'd5);
    chk("R9 sck_oe low in external mode", sck_oe, 0);
    wr(A_STAT, 8'h81);
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) ext_bit(in_b[i], cap[i]);
    wait_idle("R9");
    chk("R9 byte sent on external clock", cap, 8'hC6);
    rd(6'd5, d);
    chk("R9 byte received on external clock", d, 8'h3B);
    chk("R3 irq_o after external transfer", irq_o, 1);
    ext_bit(1'b0, cap);
    rd(A_STAT, d);
    chk("R10 overrun flag after extra clock", d & 8'h10, 8'h10);
    rd(6'd5, d);
    chk("R10 overrun moves no data", d, 8'h3B);
    wr(A_STAT, 8'h80);
    wr(A_CTRL, 8'h03);
    cs_n_i = 1'b1;
    repeat (4) @(negedge clk);
    ext_bit(1'b0, cap);
    rd(A_STAT, d);
    chk("R10 no overrun with gating and chip select high", d & 8'h10, 8'h00);
    use_ext = 1'b0;
    cs_n_i = 1'b0;
    wr(A_CTRL, 8'h00);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_gap();
    t_blocked();
    t_abort();
    t_ext();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule